// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the program counter of a small 8-bit microcontroller that uses 16-bit addresses, and it works out the address of the next instruction. Each cycle the decoder presents the length of the current instruction, a branch kind, the immediate target fields and the operand and condition values. The unit then produces the next PC, a flag that says whether the flow left the sequential path, and a write-back byte for the instructions that change their operand. For subroutine linkage it also supplies the two return-address bytes to push and takes in the two bytes that were popped.

The sequential address, `pc + ilen`, is the base for every target. A page jump keeps the top five bits of that address and takes the low eleven bits from the instruction. A long jump takes a full 16-bit target. A short jump adds a signed byte. An indirect jump loads `acc + dptr`. The conditional kinds test carry, a single bit, a zero accumulator, inequality of two operands, or the result of a decrement. The PC register loads `next_pc` on every cycle in which `step` is high.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset `pc` is 0. A branch kind that is not taken, or a kind code that is not defined, gives `next_pc = pc + ilen` (modulo 2^16) with `taken` = 0. Kind codes: 0 sequential, 1 page jump, 2 long jump, 3 short jump, 4 indirect, 5 jump-if-carry, 6 jump-if-no-carry, 7 jump-if-bit, 8 jump-if-not-bit, 9 jump-if-bit-and-clear, 10 jump-if-acc-zero, 11 jump-if-acc-nonzero, 12 compare-jump, 13 decrement-jump, 14 page call, 15 long call, 16 return.
- R2: A page jump (1) gives `next_pc = {seq[15:11], addr11}`, where `seq = pc + ilen`.
- R3: A long jump (2) gives `next_pc = addr16`.
- R4: A short jump (3) gives `next_pc = seq + sign_extend(rel8)`, which covers offsets from -128 to +127.
- R5: An indirect jump (4) gives `next_pc = acc + dptr` (modulo 2^16).
- R6: Kinds 5 to 8, 10 and 11 take the relative target when, in order, `carry` is 1, `carry` is 0, `bit_in` is 1, `bit_in` is 0, `acc` is 0, or `acc` is nonzero.
- R7: Jump-if-bit-and-clear (9) is taken when `bit_in` is 1. In that case it asserts `wb_en` with `wb_val = 0`. When `bit_in` is 0 it writes nothing back.
- R8: Compare-jump (12) is taken when `opa != opb`. It drives `cmp_carry` = 1 exactly when `opa < opb` (unsigned). For every other kind, `cmp_carry` is 0.
- R9: Decrement-jump (13) always asserts `wb_en` with `wb_val = opa - 1` (modulo 256). It is taken when that value is nonzero.
- R10: Page call (14) and long call (15) jump like kinds 1 and 2. They also assert `push_en`, with `push_lo = seq[7:0]` pushed first and `push_hi = seq[15:8]` pushed second, and `sp_delta = +2`.
- R11: Return (16) gives `next_pc = {pop_hi, pop_lo}`, `taken` = 1 and `sp_delta = -2` (3'b110). Every other kind has `sp_delta` = 0 except the calls, and `push_en` = 0.
- R12: On a clock edge with `step` high, `pc` takes the `next_pc` from before that edge. With `step` low, `pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Load `next_pc` into the PC register |
| ilen | input | 2 | Length of the current instruction in bytes |
| kind | input | 5 | Branch kind code (see R1) |
| addr11 | input | 11 | Page-jump target field |
| addr16 | input | 16 | Long target |
| rel8 | input | 8 | Signed relative offset |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| carry | input | 1 | Carry flag |
| bit_in | input | 1 | Value of the tested bit |
| opa | input | 8 | First operand for compare or decrement |
| opb | input | 8 | Second operand for compare |
| pop_hi | input | 8 | Return-address high byte popped first |
| pop_lo | input | 8 | Return-address low byte popped second |
| pc | output | 16 | Current program counter |
| next_pc | output | 16 | Address of the next instruction |
| taken | output | 1 | Flow leaves the sequential path |
| wb_en | output | 1 | Write `wb_val` back to the operand |
| wb_val | output | 8 | Write-back value |
| cmp_carry | output | 1 | Unsigned less-than result of compare-jump |
| push_en | output | 1 | Push the return address |
| push_lo | output | 8 | Return-address low byte (first push) |
| push_hi | output | 8 | Return-address high byte (second push) |
| sp_delta | output | 3 | Stack pointer change, two's complement |

## Verification
Some properties can be checked on every cycle. These are the PC register loading on `step` and holding without it, the fall-through address when no branch is taken, and the page jump keeping the upper five bits. They also cover the write-back only ever coming from the two operand-modifying kinds, and the stack adjustment agreeing with push and return. The actual target arithmetic needs the bench's sweeps. That includes sign extension, wrap past 0xFFFF, the 2K page edge and the compare carry. The sweeps run each kind across PCs, lengths, offsets, accumulator values, flags and operand pairs.

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [1:0]  ilen,
  input  logic [4:0]  kind,
  input  logic [10:0] addr11,
  input  logic [15:0] addr16,
  input  logic [7:0]  rel8,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic        carry,
  input  logic        bit_in,
  input  logic [7:0]  opa,
  input  logic [7:0]  opb,
  input  logic [7:0]  pop_hi,
  input  logic [7:0]  pop_lo,
  output logic [15:0] pc,
  output logic [15:0] next_pc,
  output logic        taken,
  output logic        wb_en,
  output logic [7:0]  wb_val,
  output logic        cmp_carry,
  output logic        push_en,
  output logic [7:0]  push_lo,
  output logic [7:0]  push_hi,
  output logic [2:0]  sp_delta
);
  localparam logic [4:0] K_SEQ = 5'd0,  K_PAGE = 5'd1, K_LONG = 5'd2,  K_SHORT = 5'd3;
  localparam logic [4:0] K_IND = 5'd4,  K_JC   = 5'd5, K_JNC  = 5'd6,  K_JB    = 5'd7;
  localparam logic [4:0] K_JNB = 5'd8,  K_JBC  = 5'd9, K_JZ   = 5'd10, K_JNZ   = 5'd11;
  localparam logic [4:0] K_CMP = 5'd12, K_DEC  = 5'd13, K_PCALL = 5'd14, K_LCALL = 5'd15;
  localparam logic [4:0] K_RET = 5'd16;

  logic [15:0] pc_q;
  logic [15:0] seq, rel_tgt, page_tgt;
  logic [7:0]  dec_val;
  logic        cond;

  assign seq      = pc_q + {14'd0, ilen};
  assign rel_tgt  = seq + {{8{rel8[7]}}, rel8};
  assign page_tgt = {seq[15:11], addr11};
  assign dec_val  = opa - 8'd1;
  assign pc       = pc_q;
  assign push_lo  = seq[7:0];
  assign push_hi  = seq[15:8];

  always_comb begin
    cond      = 1'b0;
    next_pc   = seq;
    wb_en     = 1'b0;
    wb_val    = 8'd0;
    cmp_carry = 1'b0;
    push_en   = 1'b0;
    sp_delta  = 3'd0;
    case (kind)
      K_PAGE:  begin cond = 1'b1; next_pc = page_tgt; end
      K_LONG:  begin cond = 1'b1; next_pc = addr16; end
      K_SHORT: begin cond = 1'b1; next_pc = rel_tgt; end
      K_IND:   begin cond = 1'b1; next_pc = dptr + {8'd0, acc}; end
      K_JC:    cond = carry;
      K_JNC:   cond = ~carry;
      K_JB:    cond = bit_in;
      K_JNB:   cond = ~bit_in;
      K_JBC:   begin cond = bit_in; wb_en = bit_in; end
      K_JZ:    cond = (acc == 8'd0);
      K_JNZ:   cond = (acc != 8'd0);
      K_CMP:   begin cond = (opa != opb); cmp_carry = (opa < opb); end
      K_DEC:   begin cond = (dec_val != 8'd0); wb_en = 1'b1; wb_val = dec_val; end
      K_PCALL: begin cond = 1'b1; next_pc = page_tgt; push_en = 1'b1; sp_delta = 3'd2; end
      K_LCALL: begin cond = 1'b1; next_pc = addr16;   push_en = 1'b1; sp_delta = 3'd2; end
      K_RET:   begin cond = 1'b1; next_pc = {pop_hi, pop_lo}; sp_delta = 3'b110; end
      default: cond = 1'b0;
    endcase
    if (cond && (kind >= K_JC) && (kind <= K_DEC))
      next_pc = rel_tgt;
  end

  assign taken = cond;

  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= RESET_PC;
    else if (step) pc_q <= next_pc;
  end
endmodule

module pc_branch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [1:0]  ilen,
  input logic [4:0]  kind,
  input logic [10:0] addr11,
  input logic [15:0] pc,
  input logic [15:0] next_pc,
  input logic        taken,
  input logic        wb_en,
  input logic [7:0]  wb_val,
  input logic        push_en,
  input logic [2:0]  sp_delta
);
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pc == $past(next_pc));
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc));
  a_r1_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> next_pc == pc + {14'd0, ilen});
  a_r2_page: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 5'd1) |-> (next_pc[10:0] == addr11 &&
                        next_pc[15:11] == (pc + {14'd0, ilen}) >> 11));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && kind == 5'd9) |-> (taken && wb_val == 8'd0));
  a_r9_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (kind == 5'd9 || kind == 5'd13));
  a_r10_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (sp_delta == 3'd2 && taken));
  a_r11_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_delta == 3'b110) |-> (kind == 5'd16 && !push_en));
endmodule

bind pc_branch_unit pc_branch_unit_chk u_chk (.*);

// File: tb/pc_branch_unit_tb.sv
module pc_branch_unit_tb;
  logic        clk = 0, rst_n = 0, step = 0, carry = 0, bit_in = 0;
  logic [1:0]  ilen = 1;
  logic [4:0]  kind = 0;
  logic [10:0] addr11 = 11'h5A3;
  logic [15:0] addr16 = 16'hBEEF, dptr = 16'hFFF0;
  logic [7:0]  rel8 = 0, acc = 0, opa = 0, opb = 0, pop_hi = 8'h12, pop_lo = 8'h34;
  logic [15:0] pc, next_pc;
  logic        taken, wb_en, cmp_carry, push_en;
  logic [7:0]  wb_val, push_lo, push_hi;
  logic [2:0]  sp_delta;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  pc_branch_unit u_dut (.*);

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic string req_of(input int k);
    case (k)
      1: return "R2";  2: return "R3";  3: return "R4";  4: return "R5";
      5, 6, 7, 8, 10, 11: return "R6";
      9: return "R7"; 12: return "R8"; 13: return "R9";
      14, 15: return "R10"; 16: return "R11";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [47:0] model(input logic [15:0] p, input int k);
    logic [15:0] s, n, r;
    logic t, we, cc, pe;
    logic [7:0] wv, d;
    logic [2:0] sd;
    s = p + 16'(ilen);
    r = 16'(int'(s) + int'($signed(rel8)));
    n = s; t = 0; we = 0; wv = 0; cc = 0; pe = 0; sd = 0;
    d = opa - 8'd1;
    case (k)
      1:  begin t = 1; n = {s[15:11], addr11}; end
      2:  begin t = 1; n = addr16; end
      3:  begin t = 1; n = r; end
      4:  begin t = 1; n = 16'(int'(dptr) + int'(acc)); end
      5:  t = carry;
      6:  t = !carry;
      7:  t = bit_in;
      8:  t = !bit_in;
      9:  begin t = bit_in; we = bit_in; end
      10: t = (acc == 0);
      11: t = (acc != 0);
      12: begin t = (opa != opb); cc = (int'(opa) < int'(opb)); end
      13: begin we = 1; wv = d; t = (d != 0); end
      14: begin t = 1; n = {s[15:11], addr11}; pe = 1; sd = 3'd2; end
      15: begin t = 1; n = addr16; pe = 1; sd = 3'd2; end
      16: begin t = 1; n = {pop_hi, pop_lo}; sd = 3'b110; end
      default: ;
    endcase
    if (t && k >= 5 && k <= 13) n = r;
    return {n, t, we, wv, cc, pe, s[15:8], s[7:0], sd};
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s kind=%0d pc=%h actual=%h expected=%h", req, kind, pc, act, exp);
    end
  endtask

  task automatic load_pc(input logic [15:0] v);
    @(negedge clk);
    kind = 5'd2; addr16 = v; step = 1;
    @(posedge clk); #1;
    step = 0; kind = 0; addr16 = 16'hBEEF;
    check("R12", {32'd0, pc}, {32'd0, v});
  endtask

  logic [47:0] act;
  logic [15:0] held;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {32'd0, pc}, 48'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R12", {32'd0, pc}, 48'd0);

    foreach (held[i]) ;
    for (int pi = 0; pi < 4; pi++) begin
      logic [15:0] pv;
      case (pi) 0: pv = 16'h0100; 1: pv = 16'h07FE; 2: pv = 16'hFFFE; default: pv = 16'h4080; endcase
      load_pc(pv);
      for (int k = 0; k < 18; k++)
        for (int il = 1; il < 4; il++)
          for (int ri = 0; ri < 4; ri++)
            for (int ai = 0; ai < 3; ai++)
              for (int cb = 0; cb < 4; cb++)
                for (int oi = 0; oi < 4; oi++) begin
                  kind = 5'(k); ilen = 2'(il);
                  case (ri) 0: rel8 = 8'h00; 1: rel8 = 8'h7F; 2: rel8 = 8'h80; default: rel8 = 8'hFF; endcase
                  case (ai) 0: acc = 8'h00; 1: acc = 8'h01; default: acc = 8'hFF; endcase
                  carry = cb[0]; bit_in = cb[1];
                  case (oi)
                    0: begin opa = 8'h05; opb = 8'h05; end
                    1: begin opa = 8'h01; opb = 8'hFE; end
                    2: begin opa = 8'hFE; opb = 8'h01; end
                    default: begin opa = 8'h00; opb = 8'h00; end
                  endcase
                  #1;
                  act = {next_pc, taken, wb_en, wb_val, cmp_carry, push_en, push_hi, push_lo, sp_delta};
                  check(req_of(k), act, model(pc, k));
                end
    end

    // R12: hold without step, then load a relative target with step
    @(negedge clk); kind = 5'd3; ilen = 2; rel8 = 8'hF0; step = 0;
    held = pc;
    @(posedge clk); #1;
    check("R12", {32'd0, pc}, {32'd0, held});
    @(negedge clk); step = 1;
    @(posedge clk); #1;
    step = 0;
    check("R12", {32'd0, pc}, {32'd0, 16'(held + 16'd2 - 16'd16)});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule